// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Read Engine

This block is the bus-facing slave of a byte-addressed serial memory on a two-wire bus with a clock line and a data line. It oversamples both lines with the system clock and finds START and STOP conditions. It pulls the data line low through an open-drain enable. After a START it takes in a device-select byte. On a write-direction select it accepts two word-address bytes into its address counter. On a read-direction select it sends bytes from its array, starting at the counter, for as long as the master acknowledges each byte.

A dummy write that ends in a repeated START gives a random read. A dummy write that ends in a STOP only moves the counter, and the next current-address read starts there. The counter steps once for every byte sent and wraps from the top of the array to zero. The array is a fixed pattern computed from the address, so the read path needs no storage.

Top module: `twMemSlave`

## Requirements
- R1: After reset the data line is released (`sdaPullLow` = 0) and the address counter is 0. A current-address read right after reset returns the byte at address 0.
- R2: A START is a falling data line while the clock is high. A STOP is a rising data line while the clock is high. After a STOP, every byte clocked on the bus is ignored and gets no acknowledge until the next START.
- R3: The first byte after a START is compared bit for bit. Bits 7..4 must be 1010 and bits 3..1 must equal `devSel`. Bit 0 is the direction: 1 means read, 0 means write. On a match the slave pulls the data line low for the ninth clock. On a mismatch it does not, and it ignores the bus until the next START.
- R4: After a write-direction select, the slave acknowledges two bytes. The first gives address bits ADDR_W-1..8 from its low bits, and its upper bits are ignored. The second gives address bits 7..0.
- R5: A repeated START after the second address byte, followed by a read-direction select, makes the slave send the byte at the loaded address, most significant bit first.
- R6: A STOP after the second address byte sends no data. The next current-address read returns the byte at the loaded address.
- R7: When the master acknowledges a data byte (data line low on the ninth clock), the slave sends the byte at the next address.
- R8: After address 2^ADDR_W-1 the counter wraps to 0, and reading continues while acknowledges continue.
- R9: A missing master acknowledge ends the read. The slave then drives nothing until the next START. The counter stays one past the last byte sent.
- R10: The byte at address a is ((a mod 256) XOR SEED) + floor(a/256), truncated to 8 bits.
- R11: The slave changes its drive on the data line only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| devSel | input | 3 | Strapped device-select value compared with select bits 3..1 |
| sdaPullLow | output | 1 | Open-drain enable, 1 pulls the data line low |

## Verification
The bench builds the block with ADDR_W = 9 and the default SEED, with `devSel` strapped to 101. With a 512-byte array, one sequential transfer can read every location and cross the wrap from 1FFh to 000h. The 9-bit address also leaves seven upper bits of the high address byte that must be ignored. Expected bytes come from the R10 formula evaluated in the bench.

// File: rtl/tw_pkg.sv
package tw_pkg;

  localparam int SEL_W = 3;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic start;
    logic stop;
    logic sdaBit;
  } twEvents_t;

  typedef struct packed {
    logic shiftRx;
    logic loadHi;
    logic loadLo;
    logic loadTx;
    logic shiftTx;
    logic incAddr;
    logic driveAck;
    logic driveTx;
  } twStrobes_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_HI,
    ST_HI_ACK,
    ST_LO,
    ST_LO_ACK,
    ST_TX,
    ST_TX_ACK
  } twState_t;

endpackage

// File: rtl/twDatapath.sv
module twDatapath
  import tw_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [7:0] SEED = 8'hA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  twStrobes_t        stb,
  output twEvents_t         evt,
  output logic [7:0]        rxByte,
  output logic [ADDR_W-1:0] addrCnt,
  output logic              sdaPullLow
);

  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] sclSync, sdaSync;
  logic              sclPrev, sdaPrev;
  logic              sclNow, sdaNow;
  logic [7:0]        rxShift, txShift;
  logic [ADDR_W-1:0] addrHiMerge, addrLoMerge;

  function automatic logic [7:0] romByte(input logic [ADDR_W-1:0] a);
    logic [15:0] ext;
    ext = 16'(a);
    return (ext[7:0] ^ SEED) + ext[15:8];
  endfunction

  // two-flop synchronisers plus one history flop per line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_N-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_N-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow = sclSync[SYNC_N-1];
  assign sdaNow = sdaSync[SYNC_N-1];

  always_comb begin
    evt.sclRise = sclNow & ~sclPrev;
    evt.sclFall = ~sclNow & sclPrev;
    evt.start   = sclNow & sclPrev & sdaPrev & ~sdaNow;
    evt.stop    = sclNow & sclPrev & ~sdaPrev & sdaNow;
    evt.sdaBit  = sdaNow;
  end

  generate
    if (ADDR_W > 8) begin : g_wide
      assign addrHiMerge = {rxShift[ADDR_W-9:0], addrCnt[7:0]};
      assign addrLoMerge = {addrCnt[ADDR_W-1:8], rxShift};
    end else begin : g_narrow
      assign addrHiMerge = addrCnt;
      assign addrLoMerge = rxShift[ADDR_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      addrCnt <= '0;
    end else begin
      if (stb.shiftRx) rxShift <= {rxShift[6:0], sdaNow};
      if (stb.loadTx)       txShift <= romByte(addrCnt);
      else if (stb.shiftTx) txShift <= {txShift[6:0], 1'b0};
      if (stb.loadHi)       addrCnt <= addrHiMerge;
      else if (stb.loadLo)  addrCnt <= addrLoMerge;
      else if (stb.incAddr) addrCnt <= addrCnt + 1'b1;
    end
  end

  assign rxByte     = rxShift;
  assign sdaPullLow = stb.driveAck | (stb.driveTx & ~txShift[7]);

endmodule

// File: rtl/twCtrl.sv
module twCtrl
  import tw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  twEvents_t        evt,
  input  logic [7:0]       rxByte,
  input  logic [SEL_W-1:0] devSel,
  output twStrobes_t       stb,
  output twState_t         state
);

  localparam logic [3:0] BYTE_BITS = 4'd8;
  localparam logic [3:0] ACK_BIT   = 4'd9;

  logic [3:0] bitCnt;
  logic       rdMode, masterAck;
  logic       inRx, rxDone, ackDone, devMatch;

  assign inRx     = (state == ST_DEV) || (state == ST_HI) || (state == ST_LO);
  assign rxDone   = evt.sclFall && (bitCnt == BYTE_BITS);
  assign ackDone  = evt.sclFall && (bitCnt == ACK_BIT);
  assign devMatch = (rxByte[7:4] == DEV_TYPE) && (rxByte[3:1] == devSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      rdMode    <= 1'b0;
      masterAck <= 1'b0;
    end else if (evt.start) begin
      state  <= ST_DEV;
      bitCnt <= '0;
    end else if (evt.stop) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      case (state)
        ST_DEV, ST_HI, ST_LO: begin
          if (evt.sclRise && bitCnt < BYTE_BITS) bitCnt <= bitCnt + 1'b1;
          else if (rxDone) begin
            case (state)
              ST_DEV: begin
                if (devMatch) begin
                  rdMode <= rxByte[0];
                  state  <= ST_DEV_ACK;
                end else begin
                  state  <= ST_IDLE;
                  bitCnt <= '0;
                end
              end
              ST_HI:   state <= ST_HI_ACK;
              default: state <= ST_LO_ACK;
            endcase
          end
        end
        ST_DEV_ACK, ST_HI_ACK, ST_LO_ACK: begin
          if (evt.sclRise) bitCnt <= ACK_BIT;
          else if (ackDone) begin
            bitCnt <= '0;
            case (state)
              ST_DEV_ACK: state <= rdMode ? ST_TX : ST_HI;
              ST_HI_ACK:  state <= ST_LO;
              default:    state <= ST_IDLE;
            endcase
          end
        end
        ST_TX: begin
          if (evt.sclRise && bitCnt < BYTE_BITS) bitCnt <= bitCnt + 1'b1;
          else if (rxDone) state <= ST_TX_ACK;
        end
        ST_TX_ACK: begin
          if (evt.sclRise) begin
            bitCnt    <= ACK_BIT;
            masterAck <= ~evt.sdaBit;
          end else if (ackDone) begin
            bitCnt <= '0;
            state  <= masterAck ? ST_TX : ST_IDLE;
          end
        end
        default: bitCnt <= '0;
      endcase
    end
  end

  always_comb begin
    stb.shiftRx  = inRx && evt.sclRise && (bitCnt < BYTE_BITS);
    stb.loadHi   = (state == ST_HI) && rxDone;
    stb.loadLo   = (state == ST_LO) && rxDone;
    stb.loadTx   = ackDone && (((state == ST_DEV_ACK) && rdMode) ||
                               ((state == ST_TX_ACK) && masterAck));
    stb.shiftTx  = (state == ST_TX) && evt.sclFall && (bitCnt < BYTE_BITS);
    stb.incAddr  = (state == ST_TX) && rxDone;
    stb.driveAck = (state == ST_DEV_ACK) || (state == ST_HI_ACK) || (state == ST_LO_ACK);
    stb.driveTx  = (state == ST_TX);
  end

endmodule

// File: rtl/twMemSlave.sv
module twMemSlave
  import tw_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [7:0] SEED = 8'hA5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [SEL_W-1:0] devSel,
  output logic             sdaPullLow
);

  twEvents_t         evt;
  twStrobes_t        stb;
  twState_t          ctrlState;
  logic [7:0]        rxByte;
  logic [ADDR_W-1:0] addrCnt;

  twDatapath #(.ADDR_W(ADDR_W), .SEED(SEED)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .stb(stb),
    .evt(evt), .rxByte(rxByte), .addrCnt(addrCnt), .sdaPullLow(sdaPullLow)
  );

  twCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt), .rxByte(rxByte), .devSel(devSel),
    .stb(stb), .state(ctrlState)
  );

endmodule

// File: rtl/twMemSlaveChk.sv
module twMemSlaveChk
  import tw_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaPullLow,
  input twState_t          ctrlState,
  input logic              stopSeen,
  input logic              incAddr,
  input logic [ADDR_W-1:0] addrCnt
);

  // R11: drive changes only while the raw clock line is low
  a_r11_low_phase_only: assert property (@(posedge clk) disable iff (!rstN)
    (sdaPullLow != $past(sdaPullLow)) |-> !sclIn);

  // R9: standby never drives the line
  a_r9_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_IDLE) |-> !sdaPullLow);

  // R2: a STOP sends the slave to standby with the line released
  a_r2_stop_standby: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> (ctrlState == ST_IDLE) && !sdaPullLow);

  // R7: each byte sent moves the counter by one
  a_r7_next_addr: assert property (@(posedge clk) disable iff (!rstN)
    incAddr |=> addrCnt == ADDR_W'($past(addrCnt) + 1'b1));

  // R8: the top address is followed by zero
  a_r8_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    (incAddr && addrCnt == {ADDR_W{1'b1}}) |=> addrCnt == '0);

endmodule

bind twMemSlave twMemSlaveChk #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaPullLow(sdaPullLow),
  .ctrlState(ctrlState), .stopSeen(evt.stop), .incAddr(stb.incAddr),
  .addrCnt(addrCnt)
);

// File: tb/twMemSlave_test.sv
module twMemSlave_test;

  localparam int AW = 9;
  localparam logic [7:0] SD = 8'hA5;
  localparam logic [2:0] SEL = 3'b101;
  localparam logic [7:0] RD_SEL = {4'b1010, SEL, 1'b1};
  localparam logic [7:0] WR_SEL = {4'b1010, SEL, 1'b0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaPullLow;
  logic sdaLine;
  int   nChecks = 0;
  int   nFails = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  assign sdaLine = sdaM & ~sdaPullLow;

  twMemSlave #(.ADDR_W(AW), .SEED(SD)) uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .devSel(SEL), .sdaPullLow(sdaPullLow)
  );

  function automatic logic [7:0] expByte(input int a);
    int m;
    m = a % (1 << AW);
    return 8'((((m & 255) ^ int'(SD)) + (m >> 8)) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic q();
    repeat (4) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1'b1; q(); sclM = 1'b1; q(); sdaM = 1'b0; q(); sclM = 1'b0; q();
  endtask

  task automatic stopCond();
    sdaM = 1'b0; q(); sclM = 1'b1; q(); sdaM = 1'b1; q();
  endtask

  task automatic writeBit(input logic b);
    sdaM = b; q(); sclM = 1'b1; q(); q(); sclM = 1'b0; q();
  endtask

  task automatic readBit(output logic b);
    sdaM = 1'b1; q(); sclM = 1'b1; q(); b = sdaLine; q(); sclM = 1'b0; q();
  endtask

  task automatic sendByte(input logic [7:0] v, output bit acked);
    logic b;
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(b);
    acked = ~b;
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      v[i] = b;
    end
    writeBit(~giveAck);
  endtask

  task automatic setAddr(input logic [7:0] hi, input logic [7:0] lo);
    bit a;
    startCond();
    sendByte(WR_SEL, a); check(a, "R3 write select ack", a, 1);
    sendByte(hi, a);     check(a, "R4 high address ack", a, 1);
    sendByte(lo, a);     check(a, "R4 low address ack", a, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] v;
    logic b;
    logic anyLow;
    repeat (5) @(negedge clk);
    check(sdaPullLow == 1'b0, "R1 released in reset", sdaPullLow, 0);
    rstN = 1'b1;
    q();
    check(sdaPullLow == 1'b0, "R1 released after reset", sdaPullLow, 0);

    // R1 current read from the reset address
    startCond();
    sendByte(RD_SEL, a); check(a, "R3 read select ack", a, 1);
    recvByte(1'b0, v);   check(v == expByte(0), "R1 byte at address 0", v, expByte(0));
    stopCond();

    // R3 wrong select bits, then a byte without START stays ignored
    startCond();
    sendByte({4'b1010, 3'b100, 1'b1}, a); check(!a, "R3 select mismatch nack", a, 0);
    sendByte(RD_SEL, a); check(!a, "R3 ignored until START", a, 0);
    stopCond();
    startCond();
    sendByte({4'b1011, SEL, 1'b1}, a); check(!a, "R3 device type mismatch nack", a, 0);
    stopCond();

    // R2 standby after STOP
    q();
    sendByte(RD_SEL, a); check(!a, "R2 no ack after STOP", a, 0);
    stopCond();

    // R5 random read; R4 upper bits of the high byte ignored
    setAddr(8'hFF, 8'h34);
    startCond();
    sendByte(RD_SEL, a); check(a, "R5 read select ack", a, 1);
    recvByte(1'b0, v);   check(v == expByte('h134), "R5 R4 random read", v, expByte('h134));
    stopCond();

    // R6 set current address, no data, then current read
    setAddr(8'h00, 8'h77);
    stopCond();
    anyLow = 1'b0;
    for (int i = 0; i < 9; i++) begin
      readBit(b);
      if (!b) anyLow = 1'b1;
    end
    check(!anyLow, "R6 no data after dummy write", anyLow, 0);
    stopCond();
    startCond();
    sendByte(RD_SEL, a); check(a, "R6 read select ack", a, 1);
    recvByte(1'b0, v);   check(v == expByte('h077), "R6 current read at set address", v, expByte('h077));
    stopCond();

    // R7 R8 sequential across the wrap, R9 end on nack
    setAddr(8'h01, 8'hFD);
    startCond();
    sendByte(RD_SEL, a);
    for (int k = 0; k < 5; k++) begin
      recvByte(k != 4, v);
      check(v == expByte('h1FD + k), "R7 R8 sequential byte", v, expByte('h1FD + k));
    end
    anyLow = 1'b0;
    for (int i = 0; i < 9; i++) begin
      readBit(b);
      if (!b) anyLow = 1'b1;
    end
    check(!anyLow, "R9 no drive after nack", anyLow, 0);
    stopCond();
    startCond();
    sendByte(RD_SEL, a);
    recvByte(1'b0, v); check(v == expByte(2), "R9 counter past last byte", v, expByte(2));
    stopCond();

    // R10 full array sweep with wrap
    setAddr(8'h00, 8'h00);
    startCond();
    sendByte(RD_SEL, a);
    for (int k = 0; k <= (1 << AW); k++) begin
      recvByte(k != (1 << AW), v);
      check(v == expByte(k), "R10 R8 sweep byte", v, expByte(k));
    end
    stopCond();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule